// File: doc/BRIEF.md
# Operand Address Field Decoder

This block turns the operand-addressing bytes of a variable-length instruction into the register indices and size information that later stages need to form an address. It accepts an optional register-extension prefix byte, the addressing byte (mode, register and register/memory fields) and an optional scale-index-base byte. From these it gives the register operand index, the base and index register indices with their use flags, the index scale factor, the number of displacement bytes that follow, a 64-bit operand flag, a flag that says whether the scale-index-base byte belongs to the instruction, and a flag for the instruction-pointer-relative form.

The extension prefix gives one extra bit to each 3-bit register field, so 16 registers can be named. The escape encodings are always tested on the 3-bit fields before extension. These escapes are: stack-pointer code in the register/memory field means a scale-index-base byte follows, stack-pointer code in the index field means no index, and frame-pointer code with mode 00 means no base. The result is registered: a decode presented with `in_valid` appears one clock later with `out_valid`. Address arithmetic and opcode decoding are left to other blocks.

Top module: `ead_decoder`

## Requirements
- R1: The prefix counts only when `pfx_present` is 1 and `pfx_byte[7:4]` is 4'b0100. Its bit 3 sets `wide_op`, bit 2 extends the reg field, bit 1 extends the index field and bit 0 extends the r/m or base field. A missing prefix, a prefix with any other upper nibble, and the value 0x40 all give four zero extension bits.
- R2: `reg_idx` equals {prefix bit 2, `addr_byte[5:3]`}.
- R3: `sib_used` is 1 exactly when mode `addr_byte[7:6]` is not 2'b11 and `addr_byte[2:0]` is 3'b100.
- R4: Mode 11 gives `base_idx` = {prefix bit 0, `addr_byte[2:0]`} with `base_used`=1. A memory form without a scale-index-base byte uses the same base, except mode 00 with r/m 3'b101. A form with a scale-index-base byte gives {prefix bit 0, `sib_byte[2:0]`}, except mode 00 with `sib_byte[2:0]`=3'b101. In both exceptions `base_used`=0 and `base_idx`=0.
- R5: With a scale-index-base byte, `index_idx` = {prefix bit 1, `sib_byte[5:3]`} and `index_used` is 1 unless `sib_byte[5:3]` is 3'b100. Without that byte, both are 0.
- R6: `scale_fac` is 1 << `sib_byte[7:6]` (1, 2, 4 or 8) when the scale-index-base byte is used, and 1 otherwise.
- R7: `disp_bytes` is 1 for mode 01 and 4 for mode 10. For mode 00 it is 4 when the base is suppressed and 0 otherwise. Mode 11 gives 0.
- R8: `pc_rel` is 1 exactly for mode 00 with r/m 3'b101.
- R9: The outputs change one clock after `in_valid` is sampled high. `out_valid` equals `in_valid` from the previous clock. While `in_valid` is low, the decoded outputs keep their values.
- R10: During reset (`rst_n`=0) every output is 0.
- R11: Escape tests ignore the extension bits. r/m 3'b100 with prefix bit 0 set still takes a scale-index-base byte. Index 3'b100 with prefix bit 1 set still means no index. Base or r/m 3'b101 with prefix bit 0 set and mode 00 still suppresses the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input bytes are valid this cycle |
| pfx_present | input | 1 | A prefix byte is offered |
| pfx_byte | input | 8 | Candidate register-extension prefix |
| addr_byte | input | 8 | Addressing byte: mode 7:6, reg 5:3, r/m 2:0 |
| sib_byte | input | 8 | Scale-index-base byte: scale 7:6, index 5:3, base 2:0 |
| out_valid | output | 1 | Decoded fields are valid |
| reg_idx | output | 4 | Register operand index |
| base_idx | output | 4 | Base (or second register) index |
| base_used | output | 1 | Base register takes part |
| index_idx | output | 4 | Index register index |
| index_used | output | 1 | Index register takes part |
| scale_fac | output | 4 | Index scale factor |
| disp_bytes | output | 3 | Displacement length in bytes |
| wide_op | output | 1 | 64-bit operand size |
| sib_used | output | 1 | Scale-index-base byte is consumed |
| pc_rel | output | 1 | Instruction-pointer-relative form |

## Verification
The bench builds the block with the default package widths: 3-bit encoded fields extended to 4-bit indices, a 4-bit scale output and a 3-bit displacement length. With these values all 256 addressing bytes and all 16 extension prefixes can be reached. Random stimulus therefore covers every mode, both escape codes and their extended twins 12 and 13. Directed cases pin down the escape corners, the ignored 0x40 prefix, a prefix with the wrong upper nibble, and the hold behaviour while `in_valid` is low.

// File: rtl/ead_pkg.sv
// Shared widths, codes and the decoded record for the operand address decoder.
// Assumes 3-bit encoded register fields extended by one prefix bit each.
package ead_pkg;
    parameter int FIELD_W = 3;
    parameter int IDX_W   = FIELD_W + 1;
    parameter int SCALE_W = 4;
    parameter int DISP_W  = 3;

    localparam logic [FIELD_W-1:0] CODE_SP = 3'b100;
    localparam logic [FIELD_W-1:0] CODE_FP = 3'b101;
    localparam logic [1:0]         MODE_REG = 2'b11;
    localparam logic [3:0]         PFX_TAG  = 4'b0100;

    typedef struct packed {
        logic [IDX_W-1:0]   reg_idx;
        logic [IDX_W-1:0]   base_idx;
        logic               base_used;
        logic [IDX_W-1:0]   index_idx;
        logic               index_used;
        logic [SCALE_W-1:0] scale_fac;
        logic [DISP_W-1:0]  disp_bytes;
        logic               wide_op;
        logic               sib_used;
        logic               pc_rel;
    } dec_t;
endpackage

// File: rtl/ead_prefix_unpack.sv
// Splits a candidate extension prefix into its four control bits.
// Assumes a prefix counts only if present and tagged 0100 in the upper nibble.
module ead_prefix_unpack
    import ead_pkg::*;
(
    input  logic       pfx_present,
    input  logic [7:0] pfx_byte,
    output logic       ext_w,
    output logic       ext_r,
    output logic       ext_x,
    output logic       ext_b
);
    logic hit;

    // Qualify the prefix and gate each extension bit with it.
    always_comb begin
        hit   = pfx_present && (pfx_byte[7:4] == PFX_TAG);
        ext_w = hit & pfx_byte[3];
        ext_r = hit & pfx_byte[2];
        ext_x = hit & pfx_byte[1];
        ext_b = hit & pfx_byte[0];
    end
endmodule

// File: rtl/ead_modrm_split.sv
// Decodes the addressing byte into mode class, register fields and escapes.
// Escape tests use the unextended r/m field by design.
module ead_modrm_split
    import ead_pkg::*;
(
    input  logic [7:0]       addr_byte,
    input  logic             ext_r,
    input  logic             ext_b,
    output logic [1:0]       mode,
    output logic [IDX_W-1:0] reg_full,
    output logic [IDX_W-1:0] rm_full,
    output logic             reg_direct,
    output logic             sib_follows,
    output logic             rel_form
);
    logic [FIELD_W-1:0] rm_code;

    // Slice fields, extend them and flag the two escape encodings.
    always_comb begin
        mode        = addr_byte[7:6];
        rm_code     = addr_byte[FIELD_W-1:0];
        reg_full    = {ext_r, addr_byte[5:3]};
        rm_full     = {ext_b, rm_code};
        reg_direct  = (mode == MODE_REG);
        sib_follows = !reg_direct && (rm_code == CODE_SP);
        rel_form    = (mode == 2'b00) && (rm_code == CODE_FP);
    end
endmodule

// File: rtl/ead_sib_split.sv
// Decodes a scale-index-base byte into index, scale and base information.
// Outputs are meaningful only when the addressing byte calls for this byte.
module ead_sib_split
    import ead_pkg::*;
(
    input  logic [7:0]         sib_byte,
    input  logic [1:0]         mode,
    input  logic               ext_x,
    input  logic               ext_b,
    output logic [IDX_W-1:0]   index_full,
    output logic               index_on,
    output logic [SCALE_W-1:0] scale_out,
    output logic [IDX_W-1:0]   base_full,
    output logic               base_off
);
    logic [FIELD_W-1:0] idx_code;
    logic [FIELD_W-1:0] base_code;

    // Extend index and base, resolve their escapes, expand the scale.
    always_comb begin
        idx_code   = sib_byte[5:3];
        base_code  = sib_byte[FIELD_W-1:0];
        index_full = {ext_x, idx_code};
        index_on   = (idx_code != CODE_SP);
        scale_out  = SCALE_W'(1) << sib_byte[7:6];
        base_full  = {ext_b, base_code};
        base_off   = (mode == 2'b00) && (base_code == CODE_FP);
    end
endmodule

// File: rtl/ead_decoder.sv
// Top of the operand address decoder: joins prefix, addressing and
// scale-index-base decodes and registers the result one cycle later.
// Assumes in_valid qualifies all three input bytes in the same cycle.
module ead_decoder
    import ead_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               pfx_present,
    input  logic [7:0]         pfx_byte,
    input  logic [7:0]         addr_byte,
    input  logic [7:0]         sib_byte,
    output logic               out_valid,
    output logic [IDX_W-1:0]   reg_idx,
    output logic [IDX_W-1:0]   base_idx,
    output logic               base_used,
    output logic [IDX_W-1:0]   index_idx,
    output logic               index_used,
    output logic [SCALE_W-1:0] scale_fac,
    output logic [DISP_W-1:0]  disp_bytes,
    output logic               wide_op,
    output logic               sib_used,
    output logic               pc_rel
);
    logic ext_w, ext_r, ext_x, ext_b;
    logic [1:0]         mode;
    logic [IDX_W-1:0]   reg_full, rm_full, index_full, base_full;
    logic               reg_direct, sib_follows, rel_form, index_on, base_off;
    logic [SCALE_W-1:0] scale_out;
    dec_t nxt, cur;
    logic vld_q;

    ead_prefix_unpack u_pfx (
        .pfx_present(pfx_present), .pfx_byte(pfx_byte),
        .ext_w(ext_w), .ext_r(ext_r), .ext_x(ext_x), .ext_b(ext_b)
    );

    ead_modrm_split u_modrm (
        .addr_byte(addr_byte), .ext_r(ext_r), .ext_b(ext_b),
        .mode(mode), .reg_full(reg_full), .rm_full(rm_full),
        .reg_direct(reg_direct), .sib_follows(sib_follows), .rel_form(rel_form)
    );

    ead_sib_split u_sib (
        .sib_byte(sib_byte), .mode(mode), .ext_x(ext_x), .ext_b(ext_b),
        .index_full(index_full), .index_on(index_on), .scale_out(scale_out),
        .base_full(base_full), .base_off(base_off)
    );

    // Assemble the decoded record from the three sub-decodes.
    always_comb begin
        nxt            = '0;
        nxt.reg_idx    = reg_full;
        nxt.wide_op    = ext_w;
        nxt.scale_fac  = SCALE_W'(1);
        nxt.sib_used   = sib_follows;
        nxt.pc_rel     = rel_form;
        unique case (mode)
            2'b01:   nxt.disp_bytes = DISP_W'(1);
            2'b10:   nxt.disp_bytes = DISP_W'(4);
            default: nxt.disp_bytes = '0;
        endcase
        if (reg_direct) begin
            nxt.base_idx  = rm_full;
            nxt.base_used = 1'b1;
        end else if (sib_follows) begin
            nxt.index_idx  = index_on ? index_full : '0;
            nxt.index_used = index_on;
            nxt.scale_fac  = scale_out;
            nxt.base_idx   = base_off ? '0 : base_full;
            nxt.base_used  = !base_off;
            if (base_off) nxt.disp_bytes = DISP_W'(4);
        end else begin
            nxt.base_idx  = rel_form ? '0 : rm_full;
            nxt.base_used = !rel_form;
            if (rel_form) nxt.disp_bytes = DISP_W'(4);
        end
    end

    // Capture the record on valid input; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) cur <= nxt;
        end
    end

    // Drive the ports from the registered record.
    always_comb begin
        out_valid  = vld_q;
        reg_idx    = cur.reg_idx;
        base_idx   = cur.base_idx;
        base_used  = cur.base_used;
        index_idx  = cur.index_idx;
        index_used = cur.index_used;
        scale_fac  = cur.scale_fac;
        disp_bytes = cur.disp_bytes;
        wide_op    = cur.wide_op;
        sib_used   = cur.sib_used;
        pc_rel     = cur.pc_rel;
    end
endmodule

// File: rtl/ead_decoder_chk.sv
// Property checker for the operand address decoder, bound to its top.
module ead_decoder_chk
    import ead_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               pfx_present,
    input logic [7:0]         pfx_byte,
    input logic [7:0]         addr_byte,
    input logic [7:0]         sib_byte,
    input logic               out_valid,
    input logic [IDX_W-1:0]   reg_idx,
    input logic [IDX_W-1:0]   base_idx,
    input logic               base_used,
    input logic [IDX_W-1:0]   index_idx,
    input logic               index_used,
    input logic [SCALE_W-1:0] scale_fac,
    input logic [DISP_W-1:0]  disp_bytes,
    input logic               wide_op,
    input logic               sib_used,
    input logic               pc_rel
);
    p_sib_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_byte[7:6] != 2'b11 && addr_byte[2:0] == 3'b100) |=> sib_used);

    p_wide_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !pfx_present) |=> !wide_op);

    p_no_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sib_used) |-> (!index_used && scale_fac == SCALE_W'(1)));

    p_scale_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(scale_fac) == 1));

    p_rel_disp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && pc_rel) |-> (disp_bytes == DISP_W'(4) && !base_used && !sib_used));

    p_nobase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !base_used) |-> (base_idx == '0 && disp_bytes == DISP_W'(4)));

    p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(reg_idx) && $stable(base_idx) && $stable(disp_bytes)));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

bind ead_decoder ead_decoder_chk i_chk (.*);

// File: tb/test_ead_decoder.sv
// Self-checking bench: random and directed decodes against a bench model.
module test_ead_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, pfx_present = 1'b0;
    logic [7:0] pfx_byte = '0, addr_byte = '0, sib_byte = '0;
    logic out_valid, base_used, index_used, wide_op, sib_used, pc_rel;
    logic [3:0] reg_idx, base_idx, index_idx, scale_fac;
    logic [2:0] disp_bytes;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ead_decoder i_ead_decoder (.*);

    typedef struct {
        logic [3:0] r, b, x, s;
        logic bu, xu, w, su, pr;
        logic [2:0] d;
    } exp_t;

    // Bench model written from the requirements.
    function automatic exp_t model(logic pp, logic [7:0] pb, logic [7:0] ab, logic [7:0] sb);
        exp_t e;
        logic ok, ew, er, ex, eb;
        logic [1:0] md;
        ok = pp && pb[7:4] == 4'h4;
        ew = ok && pb[3]; er = ok && pb[2]; ex = ok && pb[1]; eb = ok && pb[0];
        md = ab[7:6];
        e.r = {er, ab[5:3]}; e.w = ew;
        e.x = 0; e.xu = 0; e.s = 1; e.su = 0;
        e.pr = (md == 0 && ab[2:0] == 3'd5);
        e.d = (md == 1) ? 3'd1 : (md == 2) ? 3'd4 : 3'd0;
        if (md == 3) begin
            e.b = {eb, ab[2:0]}; e.bu = 1;
        end else if (ab[2:0] == 3'd4) begin
            e.su = 1;
            e.s = 4'd1 << sb[7:6];
            e.xu = sb[5:3] != 3'd4;
            e.x = e.xu ? {ex, sb[5:3]} : 4'd0;
            if (md == 0 && sb[2:0] == 3'd5) begin e.b = 0; e.bu = 0; e.d = 4; end
            else begin e.b = {eb, sb[2:0]}; e.bu = 1; end
        end else if (e.pr) begin
            e.b = 0; e.bu = 0; e.d = 4;
        end else begin
            e.b = {eb, ab[2:0]}; e.bu = 1;
        end
        return e;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp(exp_t e);
        chk("R1 wide_op", wide_op, e.w);
        chk("R2 reg_idx", reg_idx, e.r);
        chk("R3 sib_used", sib_used, e.su);
        chk("R4 base_idx", base_idx, e.b);
        chk("R4 base_used", base_used, e.bu);
        chk("R5 index_idx", index_idx, e.x);
        chk("R5 index_used", index_used, e.xu);
        chk("R6 scale_fac", scale_fac, e.s);
        chk("R7 disp_bytes", disp_bytes, e.d);
        chk("R8 pc_rel", pc_rel, e.pr);
    endtask

    // Apply one decode at a falling edge; check at the next falling edge.
    task automatic run(logic pp, logic [7:0] pb, logic [7:0] ab, logic [7:0] sb);
        in_valid = 1; pfx_present = pp; pfx_byte = pb; addr_byte = ab; sib_byte = sb;
        @(negedge clk);
        chk("R9 out_valid", out_valid, 1);
        cmp(model(pp, pb, ab, sb));
    endtask

    initial begin
        exp_t last;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R10 out_valid", out_valid, 0);
        chk("R10 reg_idx", reg_idx, 0);
        chk("R10 scale_fac", scale_fac, 0);
        chk("R10 disp_bytes", disp_bytes, 0);
        rst_n = 1;
        @(negedge clk);
        // Directed corners
        run(1, 8'h4F, 8'b00_111_100, 8'b11_100_101); // R11 sib with B, no index with X, no base
        run(1, 8'h41, 8'b10_000_100, 8'b01_011_101); // R11 base 13 with mode 10
        run(1, 8'h41, 8'b00_010_101, 8'h00);         // R11 pc-relative with B set
        run(1, 8'h40, 8'b11_101_110, 8'h00);         // R1 0x40 inert
        run(1, 8'h5F, 8'b01_111_111, 8'h00);         // R1 wrong nibble ignored
        run(0, 8'h4F, 8'b11_111_111, 8'h00);         // R1 absent prefix
        run(1, 8'h48, 8'b11_000_100, 8'hFF);         // R3 mode 11 no sib
        last = model(1, 8'h48, 8'b11_000_100, 8'hFF);
        // R9 hold while in_valid low
        in_valid = 0; addr_byte = 8'h15; pfx_byte = 8'h4F; sib_byte = 8'hAA;
        @(negedge clk);
        chk("R9 out_valid low", out_valid, 0);
        cmp(last);
        // Random
        for (int i = 0; i < 3000; i++)
            run($urandom_range(0, 1), ($urandom_range(0, 3) != 0) ? (8'h40 | 8'($urandom_range(0, 15))) : 8'($urandom),
                8'($urandom), 8'($urandom));
        // R10 reset clears
        rst_n = 0; in_valid = 0;
        @(negedge clk);
        chk("R10 after reset out_valid", out_valid, 0);
        chk("R10 after reset base_idx", base_idx, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule